// File: doc/BRIEF.md
# Transmit Packet Segmenter

The block sends a transfer of a programmed total length as a series of framed packets on an 8-bit streaming interface toward a MAC. A send command captures the total length and the per-packet payload size. The block then cuts the byte stream from a first-word-fall-through transmit store into payloads of that size. The last payload carries whatever remains, so it may be shorter.

Each packet opens with a fixed number of header bytes. The block fetches them from a side port that is indexed by byte offset, and the payload bytes follow. A packet starts only when the store already holds its whole payload. The output uses valid/ready flow control with start-of-packet and end-of-packet markers, and a beat stays on the bus until the MAC accepts it.

The block reports busy and the number of payload bytes still to be sent. The command and length inputs are meant to be driven from a register file.

Top module: `tx_segmenter`

## Requirements
- R1: Out of reset the block is idle: `busy`, `mac_valid` and `store_rd_en` are low and `remain_len` is 0.
- R2: A `cmd_send` pulse taken while idle with a nonzero `cfg_total_len` raises `busy` on the next cycle and loads `remain_len` with `cfg_total_len`; the payload size is captured in the same cycle.
- R3: A `cmd_send` seen while busy, or one carrying a total of zero, is ignored: busy and the remaining count of the running transfer are unaffected.
- R4: A packet starts only when `store_level` is at least its payload size, and `store_rd_en` is never asserted outside the payload phase.
- R5: A packet consists of `HDR_LEN` header bytes, taken from `hdr_data` for `hdr_idx` = 0, 1, ... `HDR_LEN`-1 in that order, followed by payload bytes popped from the store in store order.
- R6: `mac_sop` is high only with the first header byte, and `mac_eop` is high only with the last payload byte, each alongside `mac_valid`.
- R7: While `mac_valid` is high and `mac_ready` is low, the next cycle still shows `mac_valid` with unchanged `mac_data`, `mac_sop` and `mac_eop`. This holds for the first beat and for a stall in mid-packet.
- R8: Each payload holds min(captured packet size, `remain_len` at packet start) bytes, and the store is left empty once a transfer that pushed exactly its total is done.
- R9: `remain_len` drops by one for each accepted payload byte and never rises while busy. `busy` falls in the cycle after the last payload byte is accepted, with `remain_len` at 0.
- R10: Changes to `cfg_pkt_len` or `cfg_total_len` while busy do not alter the packet size or the total of the running transfer.
- R11: A `cfg_pkt_len` of 0 or above `PKT_LEN_MAX` at the moment of a send selects `PKT_LEN_DFLT` as the payload size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_send | input | 1 | Start-transfer pulse |
| cfg_pkt_len | input | PKT_W | Payload bytes per packet |
| cfg_total_len | input | LEN_W | Total payload bytes for the transfer |
| busy | output | 1 | Transfer in progress |
| remain_len | output | LEN_W | Payload bytes not yet accepted by the MAC |
| store_level | input | LVL_W | Bytes held in the transmit store |
| store_rd_en | output | 1 | Pop the head byte of the store |
| store_rd_data | input | DATA_W | Head byte of the store (fall-through) |
| hdr_idx | output | HIDX_W | Header byte offset requested |
| hdr_data | input | DATA_W | Header byte at `hdr_idx` |
| mac_valid | output | 1 | Output beat valid |
| mac_ready | input | 1 | MAC accepts the beat |
| mac_sop | output | 1 | First beat of a packet |
| mac_eop | output | 1 | Last beat of a packet |
| mac_data | output | DATA_W | Output byte |

## Verification
The assertions rely on a few properties of the inputs. `hdr_data` must be a steady function of `hdr_idx`. The store must hold its head byte and never lose bytes unless the block pops it. The configured packet size must not exceed what `store_level` can show. The bench models the store as an array whose head changes only on `store_rd_en`, and it derives header bytes arithmetically from the index. It pushes bytes in small chunks so that packet starts wait on data. It drives `mac_ready` from a pseudo-random pattern in half of the runs, and it sweeps every pair of small packet size and total length.

// File: rtl/seg_pkg.sv
package seg_pkg;
   typedef enum logic [1:0] {
      FR_WAIT = 2'd0,
      FR_HDR  = 2'd1,
      FR_PAY  = 2'd2
   } fr_state_e;
endpackage

// File: rtl/seg_len_ctrl.sv
module seg_len_ctrl #(
   parameter int LEN_W        = 32,
   parameter int PKT_W        = 16,
   parameter int PKT_LEN_MAX  = 16000,
   parameter int PKT_LEN_DFLT = 1460
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_send,
   input  logic [PKT_W-1:0] cfg_pkt_len,
   input  logic [LEN_W-1:0] cfg_total_len,
   input  logic             pay_beat,
   output logic             busy,
   output logic [LEN_W-1:0] remain,
   output logic [PKT_W-1:0] seg_len
);
   localparam logic [PKT_W-1:0] DFLT_V = PKT_W'(PKT_LEN_DFLT);
   localparam logic [PKT_W-1:0] MAX_V  = PKT_W'(PKT_LEN_MAX);

   generate
      if (LEN_W < PKT_W) begin : g_bad_len_w
         $error("seg_len_ctrl: LEN_W must not be narrower than PKT_W");
      end
      if (PKT_LEN_DFLT < 1 || PKT_LEN_DFLT > PKT_LEN_MAX) begin : g_bad_dflt
         $error("seg_len_ctrl: default size outside 1..PKT_LEN_MAX");
      end
   endgenerate

   logic             busy_q;
   logic [LEN_W-1:0] remain_q;
   logic [PKT_W-1:0] pkt_q;
   logic [PKT_W-1:0] pkt_sel;
   logic             take;

   assign take    = cmd_send && !busy_q && (cfg_total_len != '0);
   assign pkt_sel = (cfg_pkt_len == '0 || cfg_pkt_len > MAX_V) ? DFLT_V : cfg_pkt_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         remain_q <= '0;
         pkt_q    <= DFLT_V;
      end else if (take) begin
         busy_q   <= 1'b1;
         remain_q <= cfg_total_len;
         pkt_q    <= pkt_sel;
      end else if (pay_beat && busy_q) begin
         remain_q <= remain_q - 1'b1;
         if (remain_q == LEN_W'(1)) busy_q <= 1'b0;
      end
   end

   always_comb begin
      if (!busy_q)                         seg_len = '0;
      else if (remain_q < LEN_W'(pkt_q))   seg_len = remain_q[PKT_W-1:0];
      else                                 seg_len = pkt_q;
   end

   assign busy   = busy_q;
   assign remain = remain_q;

   AST_REMAIN_MONO: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && $past(busy_q) |-> remain_q <= $past(remain_q)); // R9
   AST_BUSY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> remain_q == '0); // R9
   AST_PKT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && $past(busy_q) |-> $stable(pkt_q)); // R10
   AST_SEG_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> seg_len != '0); // R8
endmodule

// File: rtl/seg_framer.sv
module seg_framer
   import seg_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int HDR_LEN = 54,
   parameter int PKT_W   = 16,
   parameter int LVL_W   = 17,
   parameter int HIDX_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy,
   input  logic [PKT_W-1:0]  seg_len,
   input  logic [LVL_W-1:0]  store_level,
   input  logic [DATA_W-1:0] store_rd_data,
   output logic              store_rd_en,
   output logic [HIDX_W-1:0] hdr_idx,
   input  logic [DATA_W-1:0] hdr_data,
   output logic              mac_valid,
   input  logic              mac_ready,
   output logic              mac_sop,
   output logic              mac_eop,
   output logic [DATA_W-1:0] mac_data,
   output logic              pay_beat
);
   localparam int CMP_W = (LVL_W > PKT_W) ? LVL_W : PKT_W;

   fr_state_e        state_q;
   logic [PKT_W-1:0] left_q;
   logic             hdr_last;
   logic             can_start;

   assign can_start = busy && (seg_len != '0) &&
                      (CMP_W'(store_level) >= CMP_W'(seg_len));

   // header index: a single-byte header needs no counter
   generate
      if (HDR_LEN == 1) begin : g_hidx_one
         assign hdr_idx  = '0;
         assign hdr_last = 1'b1;
      end else begin : g_hidx_cnt
         logic [HIDX_W-1:0] idx_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                        idx_q <= '0;
            else if (state_q == FR_WAIT)                       idx_q <= '0;
            else if (state_q == FR_HDR && mac_ready && !hdr_last) idx_q <= idx_q + 1'b1;
         end
         assign hdr_idx  = idx_q;
         assign hdr_last = (idx_q == HIDX_W'(HDR_LEN - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FR_WAIT;
         left_q  <= '0;
      end else begin
         unique case (state_q)
            FR_WAIT: if (can_start) begin
               state_q <= FR_HDR;
               left_q  <= seg_len;
            end
            FR_HDR: if (mac_ready && hdr_last) state_q <= FR_PAY;
            FR_PAY: if (mac_ready) begin
               left_q <= left_q - 1'b1;
               if (left_q == PKT_W'(1)) state_q <= FR_WAIT;
            end
            default: state_q <= FR_WAIT;
         endcase
      end
   end

   always_comb begin
      mac_valid   = 1'b0;
      mac_sop     = 1'b0;
      mac_eop     = 1'b0;
      mac_data    = '0;
      store_rd_en = 1'b0;
      pay_beat    = 1'b0;
      unique case (state_q)
         FR_HDR: begin
            mac_valid = 1'b1;
            mac_data  = hdr_data;
            mac_sop   = (hdr_idx == '0);
         end
         FR_PAY: begin
            mac_valid   = 1'b1;
            mac_data    = store_rd_data;
            mac_eop     = (left_q == PKT_W'(1));
            store_rd_en = mac_ready;
            pay_beat    = mac_ready;
         end
         default: ;
      endcase
   end

   AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      mac_valid && !mac_ready |=> mac_valid && $stable(mac_data) &&
      $stable(mac_sop) && $stable(mac_eop)); // R7
   AST_NO_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      store_rd_en |-> store_level != '0); // R4
   AST_START_ENOUGH: assert property (@(posedge clk) disable iff (!rst_n)
      mac_sop |-> CMP_W'(store_level) >= CMP_W'(left_q)); // R4
   AST_SOP_NOT_EOP: assert property (@(posedge clk) disable iff (!rst_n)
      mac_sop |-> mac_valid && !mac_eop); // R6
endmodule

// File: rtl/tx_segmenter.sv
module tx_segmenter #(
   parameter int DATA_W       = 8,
   parameter int LEN_W        = 32,
   parameter int PKT_W        = 16,
   parameter int LVL_W        = 17,
   parameter int HDR_LEN      = 54,
   parameter int PKT_LEN_MAX  = 16000,
   parameter int PKT_LEN_DFLT = 1460,
   localparam int HIDX_W      = (HDR_LEN < 2) ? 1 : $clog2(HDR_LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_send,
   input  logic [PKT_W-1:0]  cfg_pkt_len,
   input  logic [LEN_W-1:0]  cfg_total_len,
   output logic              busy,
   output logic [LEN_W-1:0]  remain_len,
   input  logic [LVL_W-1:0]  store_level,
   output logic              store_rd_en,
   input  logic [DATA_W-1:0] store_rd_data,
   output logic [HIDX_W-1:0] hdr_idx,
   input  logic [DATA_W-1:0] hdr_data,
   output logic              mac_valid,
   input  logic              mac_ready,
   output logic              mac_sop,
   output logic              mac_eop,
   output logic [DATA_W-1:0] mac_data
);
   generate
      if (HDR_LEN < 1) begin : g_bad_hdr
         $error("tx_segmenter: HDR_LEN must be at least 1");
      end
      if (PKT_LEN_MAX < 1 || PKT_LEN_MAX >= (64'd1 << PKT_W)) begin : g_bad_max
         $error("tx_segmenter: PKT_LEN_MAX does not fit PKT_W");
      end
      if (PKT_LEN_MAX >= (64'd1 << LVL_W)) begin : g_bad_lvl
         $error("tx_segmenter: store level cannot show a full packet");
      end
   endgenerate

   logic [PKT_W-1:0] seg_len;
   logic             pay_beat;

   seg_len_ctrl #(
      .LEN_W(LEN_W), .PKT_W(PKT_W),
      .PKT_LEN_MAX(PKT_LEN_MAX), .PKT_LEN_DFLT(PKT_LEN_DFLT)
   ) u_len (
      .clk(clk), .rst_n(rst_n), .cmd_send(cmd_send),
      .cfg_pkt_len(cfg_pkt_len), .cfg_total_len(cfg_total_len),
      .pay_beat(pay_beat), .busy(busy), .remain(remain_len), .seg_len(seg_len)
   );

   seg_framer #(
      .DATA_W(DATA_W), .HDR_LEN(HDR_LEN), .PKT_W(PKT_W),
      .LVL_W(LVL_W), .HIDX_W(HIDX_W)
   ) u_frm (
      .clk(clk), .rst_n(rst_n), .busy(busy), .seg_len(seg_len),
      .store_level(store_level), .store_rd_data(store_rd_data),
      .store_rd_en(store_rd_en), .hdr_idx(hdr_idx), .hdr_data(hdr_data),
      .mac_valid(mac_valid), .mac_ready(mac_ready), .mac_sop(mac_sop),
      .mac_eop(mac_eop), .mac_data(mac_data), .pay_beat(pay_beat)
   );
endmodule

// File: tb/tx_segmenter_tb.sv
`timescale 1ns/1ps
module tx_segmenter_tb;
   localparam int HDR  = 4;
   localparam int PMAX = 40;
   localparam int PDEF = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_send = 1'b0;
   logic [15:0] cfg_pkt_len = '0;
   logic [31:0] cfg_total_len = '0;
   logic        busy;
   logic [31:0] remain_len;
   logic [11:0] store_level;
   logic        store_rd_en;
   logic [7:0]  store_rd_data;
   logic [1:0]  hdr_idx;
   logic [7:0]  hdr_data;
   logic        mac_valid, mac_sop, mac_eop;
   logic        mac_ready = 1'b0;
   logic [7:0]  mac_data;

   logic [7:0] mem [0:4095];
   int wr_ptr = 0;
   int rd_ptr = 0;
   int tests = 0;
   int fails = 0;

   always #5 clk = ~clk;

   assign store_level   = 12'(wr_ptr - rd_ptr);
   assign store_rd_data = mem[rd_ptr & 4095];
   assign hdr_data      = 8'hA0 + 8'(hdr_idx);

   always @(posedge clk) if (store_rd_en) rd_ptr <= rd_ptr + 1;

   tx_segmenter #(
      .DATA_W(8), .LEN_W(32), .PKT_W(16), .LVL_W(12), .HDR_LEN(HDR),
      .PKT_LEN_MAX(PMAX), .PKT_LEN_DFLT(PDEF)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_send(cmd_send), .cfg_pkt_len(cfg_pkt_len),
      .cfg_total_len(cfg_total_len), .busy(busy), .remain_len(remain_len),
      .store_level(store_level), .store_rd_en(store_rd_en),
      .store_rd_data(store_rd_data), .hdr_idx(hdr_idx), .hdr_data(hdr_data),
      .mac_valid(mac_valid), .mac_ready(mac_ready), .mac_sop(mac_sop),
      .mac_eop(mac_eop), .mac_data(mac_data)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // monitor state
   bit        stall_mode = 1'b0;
   logic [15:0] lfsr = 16'hACE1;
   int        pos = 0, seg_exp = 0, exp_pkt = PDEF, exp_remain = 0;
   int        pay_seq = 0, pay_cnt = 0, beats = 0;
   bit        hold_armed = 1'b0;
   logic [7:0] hold_d;
   logic      hold_s, hold_e;

   always begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mac_ready = stall_mode ? (lfsr[0] | lfsr[3]) : 1'b1;
      #1;
      if (rst_n) begin
         if (hold_armed)
            chk(mac_valid && mac_data == hold_d && mac_sop == hold_s && mac_eop == hold_e,
                "R7 hold", {mac_valid, mac_data}, {1'b1, hold_d});
         hold_armed = mac_valid && !mac_ready;
         hold_d = mac_data; hold_s = mac_sop; hold_e = mac_eop;
         if (mac_valid && mac_ready) begin
            beats++;
            if (pos == 0) begin
               chk(mac_sop, "R6 sop", mac_sop, 1);
               chk(remain_len == 32'(exp_remain), "R9 remain", remain_len, exp_remain);
               seg_exp = (exp_pkt < exp_remain) ? exp_pkt : exp_remain;
            end else chk(!mac_sop, "R6 sop", mac_sop, 0);
            if (pos < HDR) begin
               chk(mac_data == 8'(8'hA0 + pos) && !mac_eop, "R5 header",
                   mac_data, 8'(8'hA0 + pos));
               pos++;
            end else begin
               chk(mac_data == 8'(pay_seq), "R5 payload", mac_data, 8'(pay_seq));
               chk(mac_eop == (pos == HDR + seg_exp - 1), "R8 eop/size", mac_eop,
                   pos == HDR + seg_exp - 1);
               pay_seq++; pay_cnt++; exp_remain--;
               if (pos == HDR + seg_exp - 1) pos = 0; else pos++;
            end
         end
      end
   end

   task automatic push(input int n);
      for (int k = 0; k < n; k++) begin
         mem[wr_ptr & 4095] = 8'(wr_ptr);
         wr_ptr++;
      end
   endtask

   task automatic run(input int p, input int t, input bit stall, input bit disturb);
      int pay0, beats0, filled, n, waitc, first;
      exp_pkt = (p == 0 || p > PMAX) ? PDEF : p;
      exp_remain = t;
      stall_mode = stall;
      pay0 = pay_cnt; beats0 = beats;
      first = (exp_pkt < t) ? exp_pkt : t;
      @(negedge clk);
      cfg_pkt_len = 16'(p); cfg_total_len = 32'(t); cmd_send = 1'b1;
      @(negedge clk);
      cmd_send = 1'b0;
      #2 chk(busy && remain_len == 32'(t), "R2 capture", remain_len, t);
      filled = 0;
      while (filled < t) begin
         n = (t - filled < 3) ? t - filled : 3;
         @(negedge clk);
         push(n);
         filled += n;
         if (filled == n && filled < first) begin
            repeat (8) @(negedge clk);
            #2 chk(beats == beats0 && !mac_valid && !store_rd_en, "R4 wait", beats - beats0, 0);
         end
         if (disturb && filled == n) begin
            @(negedge clk);
            cfg_pkt_len = 16'(p + 3); cfg_total_len = 32'd999; cmd_send = 1'b1;
            @(negedge clk);
            cmd_send = 1'b0;
            #2 chk(busy && remain_len <= 32'(t), "R3 busy send", remain_len, t);
         end
         repeat (2) @(negedge clk);
      end
      waitc = 0;
      while (busy && waitc < 5000) begin
         @(negedge clk);
         waitc++;
      end
      #2;
      chk(!busy && remain_len == 0, "R9 done", remain_len, 0);
      chk(pay_cnt - pay0 == t, "R5 total", pay_cnt - pay0, t);
      chk(store_level == 0 && pos == 0, "R8 drained", store_level, 0);
      stall_mode = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", tests, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      #2 chk(!busy && !mac_valid && !store_rd_en && remain_len == 0, "R1 reset",
             {busy, mac_valid, store_rd_en}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // zero total is ignored
      cfg_total_len = '0; cfg_pkt_len = 16'd3; cmd_send = 1'b1;
      @(negedge clk);
      cmd_send = 1'b0;
      #2 chk(!busy && remain_len == 0, "R3 zero total", busy, 0);
      repeat (5) @(negedge clk);
      #2 chk(beats == 0, "R3 zero total beats", beats, 0);

      // sweep of small sizes and totals
      for (int p = 1; p <= 5; p++)
         for (int t = 1; t <= 9; t++)
            run(p, t, ((p + t) % 2) == 1, 1'b0);

      // out-of-range size selects the default
      run(0, 13, 1'b1, 1'b0);  // R11
      run(PMAX + 1, 14, 1'b0, 1'b0);  // R11
      run(PMAX, 45, 1'b1, 1'b0);

      // reconfiguration and a new send while busy
      run(7, 40, 1'b1, 1'b1);  // R10
      run(2, 11, 1'b0, 1'b1);  // R10

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule